// File: doc/BRIEF.md
# Tag Array with Neighbour-Copy Tag Repair

This block is the tag side of a small set-associative cache: 8 sets of 4 ways and 5-bit tags. Each stored tag carries one even-parity bit, which catches a flipped tag before that tag can produce a false hit.

Each line also holds a short pointer record. When a line is filled, the block searches the two adjacent sets for a line that holds the same tag and records where that line sits. The record has three fields: a valid flag, a direction flag (lower or upper neighbour) and a way number. On a lookup, a line whose parity fails is judged by the tag of the line its record names. If the record is not valid, the line is reported as uncorrectable and cannot hit.

There are three ports. Fills arrive on a valid/ready port. Lookups use a valid/ready request and a valid/ready response. Test logic can flip stored tag and parity bits through a plain error-injection port.

Back-pressure follows these rules:
- Fills are always accepted.
- A lookup request is accepted only when no fill is offered in the same cycle and either the response register is empty or the current response is being taken.
- A response stays valid, with every field unchanged, until `rsp_ready` is high at a clock edge.

Top module: `sti_tag_corrector`

## Requirements
- R1: An 8-bit address splits into tag = bits 7:3 and set index = bits 2:0. After a fill of a tag into (set, way), a lookup of that address returns hit=1 and that way, one cycle after the request is accepted.
- R2: A lookup whose tag matches no usable line in its set returns hit=0 and way=0.
- R3: On a fill, the pointer record is built as follows. The lower neighbour set is searched first and the lowest matching way is taken. Only if the lower set has no match is the upper neighbour set searched, again taking the lowest matching way. With no match in either set the record is invalid.
- R4: A line whose stored parity fails and whose record is valid is compared using the tag of the line the record names. A match gives hit=1, and `rsp_corrected`=1 whenever such a line exists in the looked-up set.
- R5: A line whose parity fails and whose record is invalid never hits, and it sets `rsp_uncorrectable`=1 for lookups of its set.
- R6: A fill into (set s, way w) clears every record that points to it. These are records in set s-1 that point upward to way w, and records in set s+1 that point downward to way w.
- R7: Set 0 has no lower neighbour and set 7 has no upper neighbour. The search never wraps around between set 0 and set 7.
- R8: When more than one way in the set hits, `rsp_multi_hit`=1 and the returned way is the lowest hitting way.
- R9: `fill_ready` is always 1. `lk_ready` is 0 whenever `fill_valid` is 1, and also 0 while a response is held with `rsp_ready` low. An accepted lookup produces `rsp_valid` on the next cycle, and that response stays unchanged until it is taken.
- R10: After reset no line is valid, `rsp_valid`=0 and `lk_ready`=1.
- R11: `inj_mask` bits 4:0 flip the stored tag bits and bit 5 flips the stored parity bit of (`inj_set`, `inj_way`). A fill of the same line in the same cycle takes precedence and stores a clean line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted (always 1) |
| fill_addr | input | 8 | Fill address (tag and set) |
| fill_way | input | 2 | Way to write |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_addr | input | 8 | Lookup address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | A usable line matched |
| rsp_way | output | 2 | Lowest hitting way, 0 on a miss |
| rsp_corrected | output | 1 | A parity-failed line in the set was repaired |
| rsp_uncorrectable | output | 1 | A parity-failed line in the set had no valid record |
| rsp_multi_hit | output | 1 | More than one way hit |
| inj_en | input | 1 | Apply the injection mask this cycle |
| inj_set | input | 3 | Set of the line to corrupt |
| inj_way | input | 2 | Way of the line to corrupt |
| inj_mask | input | 6 | Bits to flip: 4:0 tag, 5 parity |

## Verification
A wrong pointer record does not show at the ports while a line is clean. It appears only on the first lookup after that line's tag or parity has been corrupted. At that lookup the response shows a hit where an uncorrectable miss was due, or the reverse. For this reason the tests corrupt lines on purpose and then look them up on the next cycle, so that any wrong pointer shows in that one response. A search-order fault is exposed the same way: the test overwrites the neighbour that should have been chosen, so the record should now be invalid, and a repair succeeding anyway reveals the fault. Handshake faults show within one cycle as a lost, repeated or changed response.

// File: rtl/sti_pkg.sv
package sti_pkg;
  parameter int unsigned TAG_W = 5;
  parameter int unsigned IDX_W = 3;
  parameter int unsigned WAYS  = 4;

  localparam int unsigned SETS   = 1 << IDX_W;
  localparam int unsigned ADDR_W = TAG_W + IDX_W;
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int unsigned MASK_W = TAG_W + 1;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [WAY_W-1:0] way_t;

  // pointer record kept beside every tag
  typedef struct packed {
    logic vld;
    logic up;
    way_t way;
  } sti_t;
endpackage

// File: rtl/sti_encoder.sv
module sti_encoder
  import sti_pkg::*;
(
  input  tag_t                fill_tag,
  input  logic                has_lo,
  input  logic                has_up,
  input  logic [WAYS-1:0]     lo_v,
  input  logic [WAYS-1:0]     up_v,
  input  tag_t [WAYS-1:0]     lo_tag,
  input  tag_t [WAYS-1:0]     up_tag,
  output sti_t                sti
);
  logic [WAYS-1:0] lo_m;
  logic [WAYS-1:0] up_m;

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lo_m[w] = has_lo && lo_v[w] && (lo_tag[w] == fill_tag);
      up_m[w] = has_up && up_v[w] && (up_tag[w] == fill_tag);
    end
  end

  // descending scans: lowest way wins, lower set overrides upper set
  always_comb begin
    sti = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (up_m[w]) begin
        sti.vld = 1'b1;
        sti.up  = 1'b1;
        sti.way = way_t'(w);
      end
    end
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lo_m[w]) begin
        sti.vld = 1'b1;
        sti.up  = 1'b0;
        sti.way = way_t'(w);
      end
    end
  end
endmodule

// File: rtl/sti_way_check.sv
module sti_way_check
  import sti_pkg::*;
(
  input  logic line_v,
  input  tag_t tag,
  input  logic par,
  input  sti_t sti,
  input  tag_t nb_tag,
  input  tag_t lk_tag,
  output logic hit,
  output logic fixed,
  output logic fatal
);
  logic perr;
  logic usable;
  tag_t eff_tag;

  always_comb begin
    perr    = (^tag) ^ par;
    usable  = line_v && (!perr || sti.vld);
    eff_tag = perr ? nb_tag : tag;
    hit     = usable && (eff_tag == lk_tag);
    fixed   = line_v && perr && sti.vld;
    fatal   = line_v && perr && !sti.vld;
  end
endmodule

// File: rtl/sti_lookup.sv
module sti_lookup
  import sti_pkg::*;
(
  input  tag_t                lk_tag,
  input  logic [WAYS-1:0]     cur_v,
  input  tag_t [WAYS-1:0]     cur_tag,
  input  logic [WAYS-1:0]     cur_par,
  input  sti_t [WAYS-1:0]     cur_sti,
  input  tag_t [WAYS-1:0]     lo_tag,
  input  tag_t [WAYS-1:0]     up_tag,
  output logic                hit,
  output way_t                way,
  output logic                corrected,
  output logic                uncorrectable,
  output logic                multi_hit
);
  logic [WAYS-1:0] hit_v;
  logic [WAYS-1:0] fix_v;
  logic [WAYS-1:0] bad_v;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_t nb;
    assign nb = cur_sti[w].up ? up_tag[cur_sti[w].way] : lo_tag[cur_sti[w].way];

    sti_way_check u_chk (
      .line_v (cur_v[w]),
      .tag    (cur_tag[w]),
      .par    (cur_par[w]),
      .sti    (cur_sti[w]),
      .nb_tag (nb),
      .lk_tag (lk_tag),
      .hit    (hit_v[w]),
      .fixed  (fix_v[w]),
      .fatal  (bad_v[w])
    );
  end

  always_comb begin
    int unsigned n;
    n   = 0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_v[w]) way = way_t'(w);
    end
    for (int w = 0; w < WAYS; w++) n += {31'd0, hit_v[w]};
    hit           = |hit_v;
    multi_hit     = (n > 1);
    corrected     = |fix_v;
    uncorrectable = |bad_v;
  end
endmodule

// File: rtl/sti_tag_corrector.sv
module sti_tag_corrector
  import sti_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_corrected,
  output logic              rsp_uncorrectable,
  output logic              rsp_multi_hit,
  input  logic              inj_en,
  input  logic [IDX_W-1:0]  inj_set,
  input  logic [WAY_W-1:0]  inj_way,
  input  logic [MASK_W-1:0] inj_mask
);
  localparam idx_t LAST_SET = idx_t'(SETS - 1);

  logic [SETS-1:0][WAYS-1:0] line_v;
  tag_t [SETS-1:0][WAYS-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0] par_q;
  sti_t [SETS-1:0][WAYS-1:0] sti_q;

  // fill side
  tag_t f_tag;
  idx_t f_set, f_lo, f_up;
  logic f_has_lo, f_has_up, fill_fire;
  sti_t f_sti;

  assign fill_ready = 1'b1;
  assign fill_fire  = fill_valid;
  assign f_tag      = fill_addr[ADDR_W-1:IDX_W];
  assign f_set      = fill_addr[IDX_W-1:0];
  assign f_has_lo   = (f_set != '0);
  assign f_has_up   = (f_set != LAST_SET);
  assign f_lo       = f_set - idx_t'(1);
  assign f_up       = f_set + idx_t'(1);

  sti_encoder u_enc (
    .fill_tag (f_tag),
    .has_lo   (f_has_lo),
    .has_up   (f_has_up),
    .lo_v     (line_v[f_lo]),
    .up_v     (line_v[f_up]),
    .lo_tag   (tag_q[f_lo]),
    .up_tag   (tag_q[f_up]),
    .sti      (f_sti)
  );

  // lookup side
  tag_t l_tag;
  idx_t l_set, l_lo, l_up;
  logic lk_fire;
  logic n_hit, n_corr, n_unc, n_multi;
  way_t n_way;

  assign l_tag    = lk_addr[ADDR_W-1:IDX_W];
  assign l_set    = lk_addr[IDX_W-1:0];
  assign l_lo     = l_set - idx_t'(1);
  assign l_up     = l_set + idx_t'(1);
  assign lk_ready = (!rsp_valid || rsp_ready) && !fill_valid;
  assign lk_fire  = lk_valid && lk_ready;

  sti_lookup u_lk (
    .lk_tag        (l_tag),
    .cur_v         (line_v[l_set]),
    .cur_tag       (tag_q[l_set]),
    .cur_par       (par_q[l_set]),
    .cur_sti       (sti_q[l_set]),
    .lo_tag        (tag_q[l_lo]),
    .up_tag        (tag_q[l_up]),
    .hit           (n_hit),
    .way           (n_way),
    .corrected     (n_corr),
    .uncorrectable (n_unc),
    .multi_hit     (n_multi)
  );

  // storage: injection, pointer invalidation, then fill (last write wins)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_v <= '0;
      tag_q  <= '0;
      par_q  <= '0;
      sti_q  <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (inj_en && inj_set == idx_t'(s) && inj_way == way_t'(w)) begin
            tag_q[s][w] <= tag_q[s][w] ^ inj_mask[TAG_W-1:0];
            par_q[s][w] <= par_q[s][w] ^ inj_mask[TAG_W];
          end
          if (fill_fire && sti_q[s][w].way == fill_way) begin
            if (f_has_lo && idx_t'(s) == f_lo && sti_q[s][w].up)
              sti_q[s][w].vld <= 1'b0;
            if (f_has_up && idx_t'(s) == f_up && !sti_q[s][w].up)
              sti_q[s][w].vld <= 1'b0;
          end
          if (fill_fire && f_set == idx_t'(s) && fill_way == way_t'(w)) begin
            line_v[s][w] <= 1'b1;
            tag_q[s][w]  <= f_tag;
            par_q[s][w]  <= ^f_tag;
            sti_q[s][w]  <= f_sti;
          end
        end
      end
    end
  end

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid         <= 1'b0;
      rsp_hit           <= 1'b0;
      rsp_way           <= '0;
      rsp_corrected     <= 1'b0;
      rsp_uncorrectable <= 1'b0;
      rsp_multi_hit     <= 1'b0;
    end else if (lk_fire) begin
      rsp_valid         <= 1'b1;
      rsp_hit           <= n_hit;
      rsp_way           <= n_way;
      rsp_corrected     <= n_corr;
      rsp_uncorrectable <= n_unc;
      rsp_multi_hit     <= n_multi;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sti_tag_corrector_chk.sv
module sti_tag_corrector_chk
  import sti_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fill_valid,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [WAY_W-1:0] rsp_way,
  input logic             rsp_corrected,
  input logic             rsp_uncorrectable,
  input logic             rsp_multi_hit
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid &&
      $stable({rsp_hit, rsp_way, rsp_corrected, rsp_uncorrectable, rsp_multi_hit})));

  // R9
  fill_blocks_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready);

  // R9
  accept_yields_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  // R8
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi_hit) |-> rsp_hit);

  // R2
  miss_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_way == '0));
endmodule

bind sti_tag_corrector sti_tag_corrector_chk u_sti_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .fill_valid        (fill_valid),
  .lk_valid          (lk_valid),
  .lk_ready          (lk_ready),
  .rsp_valid         (rsp_valid),
  .rsp_ready         (rsp_ready),
  .rsp_hit           (rsp_hit),
  .rsp_way           (rsp_way),
  .rsp_corrected     (rsp_corrected),
  .rsp_uncorrectable (rsp_uncorrectable),
  .rsp_multi_hit     (rsp_multi_hit)
);

// File: tb/tb_sti_tag_corrector.sv
module tb_sti_tag_corrector;
  import sti_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fill_valid = 1'b0, fill_ready;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [WAY_W-1:0]  fill_way = '0;
  logic lk_valid = 1'b0, lk_ready;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic rsp_hit, rsp_corrected, rsp_uncorrectable, rsp_multi_hit;
  logic [WAY_W-1:0] rsp_way;
  logic inj_en = 1'b0;
  logic [IDX_W-1:0]  inj_set = '0;
  logic [WAY_W-1:0]  inj_way = '0;
  logic [MASK_W-1:0] inj_mask = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sti_tag_corrector dut (.*);

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
    return {tag_t'(tag), idx_t'(set)};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input int tag, input int set, input int way);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(tag, set); fill_way = way_t'(way);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_inject(input int set, input int way, input int mask);
    @(negedge clk);
    inj_en = 1'b1; inj_set = idx_t'(set); inj_way = way_t'(way);
    inj_mask = MASK_W'(mask);
    @(posedge clk);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  // response packed as {hit, way, corrected, uncorrectable, multi}
  task automatic do_lookup(input string req, input int tag, input int set,
                           input int hit, input int way, input int corr,
                           input int unc, input int multi);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(tag, set); rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, "rsp_valid", int'(rsp_valid), 1);
    check(req, "response",
          int'({rsp_hit, rsp_way, rsp_corrected, rsp_uncorrectable, rsp_multi_hit}),
          (hit << (WAY_W + 3)) | (way << 3) | (corr << 2) | (unc << 1) | multi);
  endtask

  task automatic t_reset;
    check("R10", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R10", "lk_ready after reset", int'(lk_ready), 1);
    check("R9", "fill_ready", int'(fill_ready), 1);
    do_lookup("R10", 5, 2, 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    do_fill(5, 2, 1);
    do_lookup("R1", 5, 2, 1, 1, 0, 0, 0);
    do_lookup("R2", 6, 2, 0, 0, 0, 0, 0);
    do_lookup("R2", 5, 3, 0, 0, 0, 0, 0);
  endtask

  task automatic t_correct;
    do_fill(5, 3, 2);            // record -> lower set 2 way 1
    do_inject(3, 2, 6'h01);      // stored tag becomes 4
    do_lookup("R4", 5, 3, 1, 2, 1, 0, 0);
    do_lookup("R4", 4, 3, 0, 0, 1, 0, 0);
  endtask

  task automatic t_uncorrectable;
    do_fill(17, 5, 0);           // no neighbour holds 17
    do_inject(5, 0, 6'h04);      // stored tag becomes 21
    do_lookup("R5", 17, 5, 0, 0, 0, 1, 0);
    do_lookup("R5", 21, 5, 0, 0, 0, 1, 0);
  endtask

  task automatic t_order_invalidate;
    do_fill(9, 4, 3);
    do_fill(9, 6, 0);
    do_fill(9, 5, 1);            // R3: lower set 4 way 3 preferred over upper
    do_fill(10, 4, 3);           // R6: overwrite kills that record
    do_inject(5, 1, 6'h01);
    do_lookup("R6", 9, 5, 0, 0, 0, 1, 0);
  endtask

  task automatic t_lowest_way_multi;
    do_fill(28, 0, 1);
    do_fill(28, 0, 3);
    do_lookup("R8", 28, 0, 1, 1, 0, 0, 1);
    do_fill(28, 1, 0);           // R3: record -> lower set 0 way 1
    do_fill(2, 0, 3);            // way 3 overwritten; record must survive
    do_inject(1, 0, 6'h10);
    do_lookup("R3", 28, 1, 1, 0, 1, 0, 0);
  endtask

  task automatic t_edges;
    do_fill(19, 7, 0);
    do_fill(19, 0, 0);           // R7: set 7 is not below set 0
    do_inject(0, 0, 6'h01);
    do_lookup("R7", 19, 0, 0, 0, 0, 1, 0);
    do_fill(19, 7, 1);           // R7: set 0 is not above set 7
    do_inject(7, 1, 6'h02);
    do_lookup("R7", 19, 7, 1, 0, 0, 1, 0);
  endtask

  task automatic t_inject_rules;
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(5, 3); fill_way = 2'd2;
    inj_en = 1'b1; inj_set = 3'd3; inj_way = 2'd2; inj_mask = 6'h1f;
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0; inj_en = 1'b0;
    do_lookup("R11", 5, 3, 1, 2, 0, 0, 0);
    do_inject(3, 2, 6'h20);      // parity bit only
    do_lookup("R11", 5, 3, 1, 2, 1, 0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(5, 2); rsp_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check("R9", "rsp_valid held", int'(rsp_valid), 1);
    check("R9", "lk_ready while held", int'(lk_ready), 0);
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9", "rsp still valid", int'(rsp_valid), 1);
      check("R9", "held response", int'({rsp_hit, rsp_way}), 5);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R9", "rsp_valid after take", int'(rsp_valid), 0);
    fill_valid = 1'b1; fill_addr = mk(7, 6); fill_way = 2'd3;
    #1;
    check("R9", "lk_ready during fill", int'(lk_ready), 0);
    @(posedge clk);
    @(negedge clk);
    fill_valid = 1'b0;
    do_lookup("R1", 7, 6, 1, 3, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_correct();
    t_uncorrectable();
    t_order_invalidate();
    t_lowest_way_multi();
    t_edges();
    t_inject_rules();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule